// File: doc/BRIEF.md
# Ambient Light Register Target on I2C

This block is the serial front end of a light-sensor register bank. It watches a two-wire I2C bus through synchronizers on the local clock. It answers one of two fixed 7-bit addresses, and an input strap picks which one. Every transfer starts with a command byte that points at one 16-bit register. That register then moves as two bytes: the low byte first, then the high byte. Within each byte the most significant bit goes first.

The host writes the configuration, upper-threshold, lower-threshold and power-saving registers. These registers drive the output pins that feed the sensor core. The host reads measurement and status values with a combined transfer: it sends the address with the write bit and then the command byte, then issues a repeated START, the address with the read bit, and reads two bytes. The block drives SDA only by pulling it low (open drain), and it never holds SCL low.

The bus interface is bit-serial and has no flow control on the register side. The measurement inputs are level values that the block samples when a read starts. The register outputs are plain levels that change once, at the end of a complete write.

Top module: `als_i2c_target`

## Requirements
- R1: With `addr_sel`=1 the block answers 7-bit address 0x48 (bytes 0x90/0x91). With `addr_sel`=0 it answers 0x10 (bytes 0x20/0x21). It acknowledges the address byte by pulling SDA low during the ninth clock.
- R2: If the address does not match, the block leaves SDA released for the rest of that transaction and changes no register, until the next START or STOP.
- R3: A write is address+W, a command byte, a low byte and a high byte, and the block acknowledges all four. The addressed register takes the value {high, low} only after the high byte.
- R4: Command codes 0..3 select the configuration, upper-threshold, lower-threshold and power-saving registers, and each one drives its output pin. After reset the configuration register holds 0x0001 (shutdown) and the other three hold 0x0000.
- R5: Bits 15:3 of the power-saving register always read as zero, whatever value is written to them.
- R6: The block acknowledges writes to command codes 4..255 but discards them, and no register output changes.
- R7: In a read, the block returns {high, low} as two bytes, low byte first. Code 4 returns `light_data`, code 5 returns `white_data` and code 6 returns `irq_status`. Codes 0..3 return the stored register, and any other code returns 0x0000.
- R8: The block captures the whole 16-bit read value at the SCL fall that ends the read-address acknowledge. The high byte comes from that same capture, even if the input changes while the low byte is shifting out.
- R9: A START or STOP at any point abandons the transaction in progress. A write cut short before its high byte changes nothing.
- R10: The block raises its SDA pull-down only while SCL is low, and it releases SDA once a transaction ends. The local clock must run at least 20 times the SCL bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address strap: 1 selects 0x48, 0 selects 0x10 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| light_data | input | 16 | Main light result (code 4) |
| white_data | input | 16 | White channel result (code 5) |
| irq_status | input | 16 | Interrupt status word (code 6) |
| cfg_o | output | 16 | Configuration register (code 0) |
| thr_hi_o | output | 16 | Upper threshold register (code 1) |
| thr_lo_o | output | 16 | Lower threshold register (code 2) |
| psm_o | output | 16 | Power-saving register (code 3), bits 15:3 zero |

## Verification
The bench builds the block with its default addresses 0x48 and 0x10 and with a two-stage synchronizer. It swaps the strap between transactions, so both address matches and the mismatch path on the other address are all exercised. Most traffic runs with 40 local clocks per SCL bit. One stretch runs at 20 clocks per bit, where the acknowledge and data turnaround in the synchronizer has the least margin. The measurement input changes between the low and high byte of one read, which exercises the capture at the start of a read.

// File: rtl/als_i2c_pkg.sv
package als_i2c_pkg;
  localparam int WORD_W = 16;
  localparam int NUM_RW = 4;
  localparam int PSM_IDX = 3;
  localparam logic [7:0] CODE_LIGHT = 8'h04;
  localparam logic [7:0] CODE_WHITE = 8'h05;
  localparam logic [7:0] CODE_IRQ   = 8'h06;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WLO, S_WLACK,
    S_WHI, S_WHACK, S_TX, S_RACK, S_SKIP
  } eng_st_t;

  function automatic word_t rw_mask(input int idx);
    return (idx == PSM_IDX) ? word_t'(16'h0007) : '1;
  endfunction

  function automatic word_t rw_reset(input int idx);
    return (idx == 0) ? word_t'(16'h0001) : '0;
  endfunction
endpackage

// File: rtl/als_i2c_busmon.sv
module als_i2c_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  assign scl_now   = scl_pipe[DEPTH-2];
  assign scl_old   = scl_pipe[DEPTH-1];
  assign sda_s     = sda_pipe[DEPTH-2];
  assign sda_old   = sda_pipe[DEPTH-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/als_i2c_engine.sv
module als_i2c_engine
  import als_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_HI = 7'h48,
  parameter logic [6:0] ADDR_LO = 7'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  word_t      rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output word_t      wr_data,
  output logic       sda_oe,
  output eng_st_t    state
);
  eng_st_t    st;
  logic [3:0] cnt;
  logic [7:0] shreg, lo_buf;
  word_t      tx_word;
  logic       hi_sel, is_read, host_ack;
  logic [6:0] my_addr;
  logic [7:0] tx_byte;
  logic       tx_bit;

  assign my_addr = addr_sel ? ADDR_HI : ADDR_LO;
  assign tx_byte = hi_sel ? tx_word[15:8] : tx_word[7:0];
  assign tx_bit  = tx_byte[3'd7 - cnt[2:0]];
  assign state   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; shreg <= '0; lo_buf <= '0; ptr <= '0;
      tx_word <= '0; hi_sel <= 1'b0; is_read <= 1'b0; host_ack <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WLO, S_WHI: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (st)
                S_ADDR: begin
                  if (shreg[7:1] == my_addr) begin
                    is_read <= shreg[0]; sda_oe <= 1'b1; st <= S_AACK;
                  end else begin
                    st <= S_SKIP;
                  end
                end
                S_CMD: begin
                  ptr <= shreg; sda_oe <= 1'b1; st <= S_CACK;
                end
                S_WLO: begin
                  lo_buf <= shreg; sda_oe <= 1'b1; st <= S_WLACK;
                end
                default: begin
                  wr_data <= {shreg, lo_buf}; wr_en <= 1'b1;
                  sda_oe <= 1'b1; st <= S_WHACK;
                end
              endcase
            end
          end
          S_AACK: if (scl_fall) begin
            if (is_read) begin
              tx_word <= rd_data; hi_sel <= 1'b0;
              sda_oe <= ~rd_data[7]; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_CMD;
            end
          end
          S_CACK:  if (scl_fall) begin sda_oe <= 1'b0; st <= S_WLO;  end
          S_WLACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WHI;  end
          S_WHACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_SKIP; end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; cnt <= '0; st <= S_RACK;
              end else begin
                sda_oe <= ~tx_bit;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack && !hi_sel) begin
                hi_sel <= 1'b1; sda_oe <= ~tx_word[15]; st <= S_TX;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/als_i2c_regs.sv
module als_i2c_regs
  import als_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] ptr,
  input  word_t      wr_data,
  input  word_t      light_data,
  input  word_t      white_data,
  input  word_t      irq_status,
  output word_t      rd_data,
  output word_t      cfg_o,
  output word_t      thr_hi_o,
  output word_t      thr_lo_o,
  output word_t      psm_o
);
  localparam int IDX_W = $clog2(NUM_RW);

  word_t rw_q [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_q[g] <= rw_reset(g);
      else if (wr_en && ptr == 8'(g)) rw_q[g] <= wr_data & rw_mask(g);
    end
  end

  always_comb begin
    if (ptr < 8'(NUM_RW)) rd_data = rw_q[ptr[IDX_W-1:0]];
    else if (ptr == CODE_LIGHT) rd_data = light_data;
    else if (ptr == CODE_WHITE) rd_data = white_data;
    else if (ptr == CODE_IRQ) rd_data = irq_status;
    else rd_data = '0;
  end

  assign cfg_o    = rw_q[0];
  assign thr_hi_o = rw_q[1];
  assign thr_lo_o = rw_q[2];
  assign psm_o    = rw_q[PSM_IDX];
endmodule

// File: rtl/als_i2c_target.sv
module als_i2c_target
  import als_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_HI     = 7'h48,
  parameter logic [6:0] ADDR_LO     = 7'h10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_sel,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [15:0] light_data,
  input  logic [15:0] white_data,
  input  logic [15:0] irq_status,
  output logic [15:0] cfg_o,
  output logic [15:0] thr_hi_o,
  output logic [15:0] thr_lo_o,
  output logic [15:0] psm_o
);
  logic       scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic [7:0] ptr;
  logic       wr_en;
  word_t      wr_data, rd_data;
  eng_st_t    eng_state;

  als_i2c_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  als_i2c_engine #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_engine (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe),
    .state(eng_state)
  );

  als_i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .light_data(light_data), .white_data(white_data), .irq_status(irq_status),
    .rd_data(rd_data), .cfg_o(cfg_o), .thr_hi_o(thr_hi_o),
    .thr_lo_o(thr_lo_o), .psm_o(psm_o)
  );
endmodule

// File: rtl/als_i2c_checker.sv
module als_i2c_checker
  import als_i2c_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [15:0] cfg_o,
  input logic [15:0] thr_hi_o,
  input logic [15:0] thr_lo_o,
  input logic [15:0] psm_o,
  input logic        wr_en,
  input logic [7:0]  ptr,
  input eng_st_t     eng_state
);
  // R4: configuration comes out of reset in shutdown
  a_r4_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_o == 16'h0001);

  // R5: power-saving upper bits never set
  a_r5_psm_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    psm_o[15:3] == 13'd0);

  // R10: pull-down only starts while SCL is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R2: no drive while ignoring the bus
  a_r2_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    eng_state == S_SKIP |-> !sda_oe);

  // R3: writable registers move only on a commit
  a_r3_no_commit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({cfg_o, thr_hi_o, thr_lo_o, psm_o}));

  // R6: commits to read-only codes leave registers unchanged
  a_r6_ro_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr >= 8'd4) |=> $stable({cfg_o, thr_hi_o, thr_lo_o, psm_o}));
endmodule

bind als_i2c_target als_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_o(cfg_o), .thr_hi_o(thr_hi_o), .thr_lo_o(thr_lo_o), .psm_o(psm_o),
  .wr_en(wr_en), .ptr(ptr), .eng_state(eng_state)
);

// File: tb/als_i2c_target_bench.sv
module als_i2c_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [15:0] light_data = '0, white_data = '0, irq_status = '0;
  logic [15:0] cfg_o, thr_hi_o, thr_lo_o, psm_o;
  int q = 10;
  int errors = 0, checks = 0;
  logic [15:0] model [4];

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  als_i2c_target u_als_i2c_target (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl),
    .sda_i(sda_line), .sda_oe(sda_oe), .light_data(light_data),
    .white_data(white_data), .irq_status(irq_status), .cfg_o(cfg_o),
    .thr_hi_o(thr_hi_o), .thr_lo_o(thr_lo_o), .psm_o(psm_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(q); m_scl = 1'b1; wq(q); m_sda = 1'b0; wq(q); m_scl = 1'b0; wq(q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(q); m_scl = 1'b1; wq(q); m_sda = 1'b1; wq(q);
  endtask

  task automatic bit_cycle(input logic drv, output logic smp);
    m_sda = drv; wq(q); m_scl = 1'b1; wq(q); smp = sda_line; wq(q); m_scl = 1'b0; wq(q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = !s;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, s); d[i] = s; end
    bit_cycle(!give_ack, s);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] code,
                          input logic [15:0] v, output bit ok);
    bit k0, k1, k2, k3;
    i2c_start();
    wbyte({a, 1'b0}, k0);
    wbyte(code, k1); wbyte(v[7:0], k2); wbyte(v[15:8], k3);
    i2c_stop();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] code,
                         input bit poke, input logic [15:0] poke_v,
                         output logic [15:0] v, output bit ok);
    bit k0, k1, k2;
    i2c_start();
    wbyte({a, 1'b0}, k0); wbyte(code, k1);
    i2c_start();
    wbyte({a, 1'b1}, k2);
    rbyte(1'b1, v[7:0]);
    if (poke) light_data = poke_v;
    rbyte(1'b0, v[15:8]);
    i2c_stop();
    ok = k0 & k1 & k2;
  endtask

  function automatic logic [6:0] my_addr(input logic s);
    return s ? 7'h48 : 7'h10;
  endfunction

  function automatic logic [15:0] store_val(input int code, input logic [15:0] v);
    return (code == 3) ? (v & 16'h0007) : v;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] code);
    if (code < 8'd4) return model[code[1:0]];
    if (code == 8'd4) return light_data;
    if (code == 8'd5) return white_data;
    if (code == 8'd6) return irq_status;
    return 16'h0000;
  endfunction

  function automatic logic [63:0] regs_now();
    return {cfg_o, thr_hi_o, thr_lo_o, psm_o};
  endfunction

  function automatic logic [63:0] regs_exp();
    return {model[0], model[1], model[2], model[3]};
  endfunction

  task automatic check_regs(input string req);
    chk(regs_now() == regs_exp(), req, regs_now()[31:0] ^ regs_now()[63:32], regs_exp()[31:0] ^ regs_exp()[63:32]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [15:0] rv, v;
    logic [7:0] code;
    void'($urandom(32'h1234_5a5a));
    model[0] = 16'h0001; model[1] = '0; model[2] = '0; model[3] = '0;
    wq(5); rst_n = 1'b1; wq(3);

    // R4 reset values, R10 released
    chk(cfg_o == 16'h0001, "R4 cfg reset", cfg_o, 16'h0001);
    chk({thr_hi_o, thr_lo_o, psm_o} == '0, "R4 others reset", {thr_hi_o, psm_o}, 0);
    chk(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);

    // R1 R3 write config at 0x48
    do_write(7'h48, 8'h00, 16'h1A42, ok); model[0] = 16'h1A42;
    chk(ok, "R1 R3 write acks", ok, 1);
    chk(cfg_o == 16'h1A42, "R3 cfg value", cfg_o, 16'h1A42);
    chk(sda_oe == 1'b0, "R10 release after write", sda_oe, 0);
    do_write(7'h48, 8'h01, 16'hBEEF, ok); model[1] = 16'hBEEF;
    do_write(7'h48, 8'h02, 16'h0123, ok); model[2] = 16'h0123;
    check_regs("R4 thresholds");

    // R5 power-saving mask
    do_write(7'h48, 8'h03, 16'hFFFF, ok); model[3] = 16'h0007;
    chk(psm_o == 16'h0007, "R5 psm mask", psm_o, 16'h0007);

    // R2 wrong address with strap high
    do_write(7'h10, 8'h00, 16'h5555, ok);
    chk(!ok, "R2 no ack", ok, 0);
    check_regs("R2 no change");

    // R1 strap low
    addr_sel = 1'b0; wq(q);
    do_write(7'h10, 8'h02, 16'h7788, ok); model[2] = 16'h7788;
    chk(ok && thr_lo_o == 16'h7788, "R1 strap low", thr_lo_o, 16'h7788);
    do_write(7'h48, 8'h02, 16'h0000, ok);
    chk(!ok && thr_lo_o == 16'h7788, "R2 strap low mismatch", thr_lo_o, 16'h7788);
    addr_sel = 1'b1; wq(q);

    // R6 write to read-only code
    light_data = 16'hC3A5;
    do_write(7'h48, 8'h04, 16'h1111, ok);
    chk(ok, "R6 ro write acked", ok, 1);
    check_regs("R6 ro discarded");
    do_read(7'h48, 8'h04, 1'b0, 16'h0, rv, ok);
    chk(ok && rv == 16'hC3A5, "R7 light read", rv, 16'hC3A5);

    // R7 other codes
    white_data = 16'h0F1E; irq_status = 16'h8000;
    do_read(7'h48, 8'h05, 1'b0, 16'h0, rv, ok);
    chk(rv == 16'h0F1E, "R7 white read", rv, 16'h0F1E);
    do_read(7'h48, 8'h06, 1'b0, 16'h0, rv, ok);
    chk(rv == 16'h8000, "R7 status read", rv, 16'h8000);
    do_read(7'h48, 8'h09, 1'b0, 16'h0, rv, ok);
    chk(rv == 16'h0000, "R7 undefined read", rv, 0);

    // R8 capture coherence
    light_data = 16'h12AB;
    do_read(7'h48, 8'h04, 1'b1, 16'hFE00, rv, ok);
    chk(rv == 16'h12AB, "R8 coherent word", rv, 16'h12AB);

    // R9 write abandoned by STOP after low byte
    begin
      bit k;
      i2c_start(); wbyte(8'h90, k); wbyte(8'h01, k); wbyte(8'h44, k); i2c_stop();
      check_regs("R9 stop abort");
      i2c_start(); wbyte(8'h90, k); wbyte(8'h01, k);
      i2c_start(); wbyte(8'h90, k); wbyte(8'h02, k); wbyte(8'h34, k); wbyte(8'h12, k); i2c_stop();
      model[2] = 16'h1234;
      check_regs("R9 restart abort");
    end

    // random mix, second half at 20 clocks per bit
    for (int it = 0; it < 40; it++) begin
      if (it == 20) q = 5;
      addr_sel = 1'($urandom_range(0, 1)); wq(q);
      code = 8'($urandom_range(0, 8));
      v = 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        do_write(my_addr(!addr_sel), code, v, ok);
        chk(!ok, "R2 random mismatch", ok, 0);
      end else if ($urandom_range(0, 1) == 0) begin
        do_write(my_addr(addr_sel), code, v, ok);
        if (code < 8'd4) model[code[1:0]] = store_val(int'(code), v);
        chk(ok, "R3 random write ack", ok, 1);
      end else begin
        light_data = 16'($urandom); white_data = 16'($urandom); irq_status = 16'($urandom);
        do_read(my_addr(addr_sel), code, 1'b0, 16'h0, rv, ok);
        chk(ok && rv == exp_read(code), "R7 random read", rv, exp_read(code));
      end
      check_regs("R4 R5 random regs");
      chk(sda_oe == 1'b0, "R10 random release", sda_oe, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule